// File: doc/BRIEF.md
# Programmable Wait-State Bus Sequencer

This block is the cycle-level sequencer of a processor-style external bus. A bus queue tells it that a request is pending, whether that request is a read or a write, and how many data beats it carries. Each region supplies programmable wait counts. The sequencer then steps through an address phase, optional address-to-data wait cycles, one or more data beats with optional waits between beats, and an optional recovery gap before the next access may start. At each point it honours the external hold request, the back-off request, the beat acknowledge and burst-stop inputs, the synchronous reset and a test-isolation input.

Three independent down-counters time the waits. Each one loads its programmed value when its wait state is entered and advances the machine when it reaches one. A back-off request suspends the access in progress. The suspended phase and every counter are frozen until the request is released, and then the access resumes where it stopped. The current state is exported with address and data strobes and a flag that marks the final data beat.

Top module: `wsbus_seq`

## Requirements
- R1: State codes are IDLE=0, HOLD=1, ADDR=2, DATA=3, BACKOFF=4, A2D wait=5, D2D wait=6, RECOVERY=7, ISOLATE=8, and `state_o` never shows any other code. When `sync_rst` is high at a clock edge and `test_isolate` is low, the next state is IDLE, except that the ISOLATE state is left as described in R3.
- R2: In IDLE with the reset low, a high `bus_hold_req` leads to HOLD. Otherwise a pending request leads to ADDR, and with neither the state remains IDLE. HOLD returns to IDLE in the cycle after `bus_hold_req` is low.
- R3: `sync_rst` and `test_isolate` both high at an edge lead to ISOLATE from any state. ISOLATE persists while `test_isolate` is high and goes to IDLE on the first edge where it is low.
- R4: From ADDR, if the captured address-to-data count is nonzero (the write count for a write, otherwise the read count), the machine spends exactly that many cycles in the A2D wait state and then enters DATA. With a zero count it goes from ADDR straight to DATA.
- R5: After a data beat that is not the last one, a nonzero captured data-to-data count (write or read, as in R4) inserts exactly that many D2D wait cycles before the next DATA cycle. A zero count goes directly to the next DATA cycle.
- R6: When `ext_rdy_en` is high, a DATA cycle with both `beat_ack` and `burst_stop` low completes no beat: the state stays DATA and `last_beat` keeps its value. When `ext_rdy_en` is low, every DATA cycle without back-off completes a beat.
- R7: An access carries `req_beats` beats, where 0 counts as 1. `last_beat` is high exactly in DATA cycles of the final beat. After the final beat completes, a nonzero recovery count leads to RECOVERY. With a zero count the next state is HOLD if hold is requested, else ADDR if a request is pending, else IDLE.
- R8: RECOVERY lasts exactly the captured recovery count in cycles. It then leads to HOLD if hold is requested, else ADDR if a request is pending, else IDLE.
- R9: `backoff_req` high in ADDR, A2D, DATA or D2D leads to BACKOFF. BACKOFF persists while the request stays high. On release the machine returns to the interrupted state with its remaining wait count and beat count unchanged.
- R10: The write flag, beat count and all five wait counts are captured when an access enters ADDR from IDLE, DATA or RECOVERY. Later changes on those inputs do not affect the access in progress.
- R11: `addr_strobe` is high exactly in ADDR and `data_strobe` exactly in DATA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sync_rst | input | 1 | Synchronous reset to IDLE |
| test_isolate | input | 1 | Test isolation request, taken with reset |
| req_pending | input | 1 | Bus queue holds at least one request |
| req_write | input | 1 | Pending request is a write |
| req_beats | input | BEAT_W | Beats in the pending request (0 means 1) |
| rd_a2d_cnt | input | CNT_W | Read address-to-data wait count |
| wr_a2d_cnt | input | CNT_W | Write address-to-data wait count |
| rd_d2d_cnt | input | CNT_W | Read data-to-data wait count |
| wr_d2d_cnt | input | CNT_W | Write data-to-data wait count |
| recov_cnt | input | CNT_W | Recovery cycles after the last beat |
| ext_rdy_en | input | 1 | Beats wait for an external acknowledge |
| bus_hold_req | input | 1 | External bus hold request |
| backoff_req | input | 1 | Suspend the current access |
| beat_ack | input | 1 | External acknowledge of a data beat |
| burst_stop | input | 1 | External burst terminate, completes a beat |
| state_o | output | 4 | Current state code |
| addr_strobe | output | 1 | Address phase active |
| data_strobe | output | 1 | Data phase active |
| last_beat | output | 1 | Current data cycle is the final beat |

## Verification
The properties assume that every input is at a known level whenever reset is low, and that inputs change only between clock edges. Inputs sampled in a cycle are therefore taken as the values the machine reacts to. The bench drives all inputs at the falling edge from directed sequences and from a fixed-seed random stream. In that stream, hold, back-off, reset and isolation are rare, and counts and beat numbers are kept small so that every wait state and its exits are reached many times.

// File: rtl/wsbus_pkg.sv
package wsbus_pkg;
   typedef enum logic [3:0] {
      ST_IDLE  = 4'd0,
      ST_HOLD  = 4'd1,
      ST_ADDR  = 4'd2,
      ST_DATA  = 4'd3,
      ST_BOFF  = 4'd4,
      ST_A2D   = 4'd5,
      ST_D2D   = 4'd6,
      ST_RECOV = 4'd7,
      ST_ISO   = 4'd8
   } bus_st_e;

   localparam int NUM_WAIT = 3;
   localparam int WI_A2D   = 0;
   localparam int WI_D2D   = 1;
   localparam int WI_REC   = 2;
endpackage

// File: rtl/wsbus_wait_cnt.sv
module wsbus_wait_cnt #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             at_one
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)       cnt_q <= '0;
      else if (load) cnt_q <= load_val;
      else if (dec)  cnt_q <= cnt_q - 1'b1;
   end

   assign at_one = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/wsbus_access.sv
module wsbus_access #(
   parameter int CNT_W  = 5,
   parameter int BEAT_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              capture,
   input  logic              beat_done,
   input  logic              req_write,
   input  logic [BEAT_W-1:0] req_beats,
   input  logic [CNT_W-1:0]  rd_a2d_cnt,
   input  logic [CNT_W-1:0]  wr_a2d_cnt,
   input  logic [CNT_W-1:0]  rd_d2d_cnt,
   input  logic [CNT_W-1:0]  wr_d2d_cnt,
   input  logic [CNT_W-1:0]  recov_cnt,
   output logic [CNT_W-1:0]  sel_a2d,
   output logic [CNT_W-1:0]  sel_d2d,
   output logic [CNT_W-1:0]  sel_rec,
   output logic              is_last
);
   logic [BEAT_W-1:0] beats_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_a2d <= '0;
         sel_d2d <= '0;
         sel_rec <= '0;
         beats_q <= '0;
      end else if (capture) begin
         sel_a2d <= req_write ? wr_a2d_cnt : rd_a2d_cnt;
         sel_d2d <= req_write ? wr_d2d_cnt : rd_d2d_cnt;
         sel_rec <= recov_cnt;
         beats_q <= (req_beats == '0) ? BEAT_W'(1) : req_beats;
      end else if (beat_done && beats_q > BEAT_W'(1)) begin
         beats_q <= beats_q - 1'b1;
      end
   end

   assign is_last = (beats_q <= BEAT_W'(1));
endmodule

// File: rtl/wsbus_fsm.sv
module wsbus_fsm
   import wsbus_pkg::*;
(
   input  bus_st_e state,
   input  bus_st_e saved,
   input  logic    sync_rst,
   input  logic    test_isolate,
   input  logic    req_pending,
   input  logic    bus_hold_req,
   input  logic    backoff_req,
   input  logic    beat_ack,
   input  logic    burst_stop,
   input  logic    ext_rdy_en,
   input  logic    a2d_nz,
   input  logic    d2d_nz,
   input  logic    rec_nz,
   input  logic    a2d_one,
   input  logic    d2d_one,
   input  logic    rec_one,
   input  logic    is_last,
   output bus_st_e nxt,
   output logic    beat_done
);
   bus_st_e after_acc;

   assign beat_done = (state == ST_DATA) && !backoff_req &&
                      (!ext_rdy_en || beat_ack || burst_stop);

   always_comb begin
      if (bus_hold_req)     after_acc = ST_HOLD;
      else if (req_pending) after_acc = ST_ADDR;
      else                  after_acc = ST_IDLE;
   end

   always_comb begin
      nxt = state;
      if (sync_rst && test_isolate) begin
         nxt = ST_ISO;
      end else if (state == ST_ISO) begin
         nxt = test_isolate ? ST_ISO : ST_IDLE;
      end else if (sync_rst) begin
         nxt = ST_IDLE;
      end else begin
         unique case (state)
            ST_IDLE:  nxt = after_acc;
            ST_HOLD:  if (!bus_hold_req) nxt = ST_IDLE;
            ST_ADDR: begin
               if (backoff_req) nxt = ST_BOFF;
               else if (a2d_nz) nxt = ST_A2D;
               else             nxt = ST_DATA;
            end
            ST_A2D: begin
               if (backoff_req)  nxt = ST_BOFF;
               else if (a2d_one) nxt = ST_DATA;
            end
            ST_DATA: begin
               if (backoff_req) nxt = ST_BOFF;
               else if (beat_done) begin
                  if (is_last) nxt = rec_nz ? ST_RECOV : after_acc;
                  else         nxt = d2d_nz ? ST_D2D : ST_DATA;
               end
            end
            ST_D2D: begin
               if (backoff_req)  nxt = ST_BOFF;
               else if (d2d_one) nxt = ST_DATA;
            end
            ST_RECOV: if (rec_one) nxt = after_acc;
            ST_BOFF:  if (!backoff_req) nxt = saved;
            default:  nxt = ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/wsbus_seq.sv
module wsbus_seq
   import wsbus_pkg::*;
#(
   parameter int CNT_W  = 5,
   parameter int BEAT_W = 4
) (
   input  logic              clk,
   input  logic              sync_rst,
   input  logic              test_isolate,
   input  logic              req_pending,
   input  logic              req_write,
   input  logic [BEAT_W-1:0] req_beats,
   input  logic [CNT_W-1:0]  rd_a2d_cnt,
   input  logic [CNT_W-1:0]  wr_a2d_cnt,
   input  logic [CNT_W-1:0]  rd_d2d_cnt,
   input  logic [CNT_W-1:0]  wr_d2d_cnt,
   input  logic [CNT_W-1:0]  recov_cnt,
   input  logic              ext_rdy_en,
   input  logic              bus_hold_req,
   input  logic              backoff_req,
   input  logic              beat_ack,
   input  logic              burst_stop,
   output logic [3:0]        state_o,
   output logic              addr_strobe,
   output logic              data_strobe,
   output logic              last_beat
);
   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("CNT_W must be at least 2");
   end
   if (BEAT_W < 1) begin : g_bad_beat_w
      $error("BEAT_W must be at least 1");
   end

   bus_st_e state_q, saved_q, nxt;
   logic beat_done, is_last, capture;
   logic [CNT_W-1:0] sel_a2d, sel_d2d, sel_rec;
   logic [CNT_W-1:0] w_val  [NUM_WAIT];
   logic             w_load [NUM_WAIT];
   logic             w_dec  [NUM_WAIT];
   logic             w_one  [NUM_WAIT];
   bus_st_e          w_state[NUM_WAIT];

   assign capture = (nxt == ST_ADDR) &&
                    (state_q == ST_IDLE || state_q == ST_DATA || state_q == ST_RECOV);

   wsbus_access #(.CNT_W(CNT_W), .BEAT_W(BEAT_W)) u_access (
      .clk        (clk),
      .rst        (sync_rst),
      .capture    (capture),
      .beat_done  (beat_done),
      .req_write  (req_write),
      .req_beats  (req_beats),
      .rd_a2d_cnt (rd_a2d_cnt),
      .wr_a2d_cnt (wr_a2d_cnt),
      .rd_d2d_cnt (rd_d2d_cnt),
      .wr_d2d_cnt (wr_d2d_cnt),
      .recov_cnt  (recov_cnt),
      .sel_a2d    (sel_a2d),
      .sel_d2d    (sel_d2d),
      .sel_rec    (sel_rec),
      .is_last    (is_last)
   );

   assign w_val[WI_A2D]   = sel_a2d;
   assign w_val[WI_D2D]   = sel_d2d;
   assign w_val[WI_REC]   = sel_rec;
   assign w_state[WI_A2D] = ST_A2D;
   assign w_state[WI_D2D] = ST_D2D;
   assign w_state[WI_REC] = ST_RECOV;

   for (genvar gi = 0; gi < NUM_WAIT; gi++) begin : g_wait
      assign w_load[gi] = (nxt == w_state[gi]) && (state_q != w_state[gi]) &&
                          (state_q != ST_BOFF);
      assign w_dec[gi]  = (state_q == w_state[gi]) && (nxt == w_state[gi]);
      wsbus_wait_cnt #(.CNT_W(CNT_W)) u_cnt (
         .clk      (clk),
         .rst      (sync_rst),
         .load     (w_load[gi]),
         .load_val (w_val[gi]),
         .dec      (w_dec[gi]),
         .at_one   (w_one[gi])
      );
   end

   wsbus_fsm u_fsm (
      .state        (state_q),
      .saved        (saved_q),
      .sync_rst     (sync_rst),
      .test_isolate (test_isolate),
      .req_pending  (req_pending),
      .bus_hold_req (bus_hold_req),
      .backoff_req  (backoff_req),
      .beat_ack     (beat_ack),
      .burst_stop   (burst_stop),
      .ext_rdy_en   (ext_rdy_en),
      .a2d_nz       (sel_a2d != '0),
      .d2d_nz       (sel_d2d != '0),
      .rec_nz       (sel_rec != '0),
      .a2d_one      (w_one[WI_A2D]),
      .d2d_one      (w_one[WI_D2D]),
      .rec_one      (w_one[WI_REC]),
      .is_last      (is_last),
      .nxt          (nxt),
      .beat_done    (beat_done)
   );

   always_ff @(posedge clk) begin
      state_q <= nxt;
      if (sync_rst)
         saved_q <= ST_IDLE;
      else if (nxt == ST_BOFF && state_q != ST_BOFF)
         saved_q <= state_q;
   end

   assign state_o     = state_q;
   assign addr_strobe = (state_q == ST_ADDR);
   assign data_strobe = (state_q == ST_DATA);
   assign last_beat   = (state_q == ST_DATA) && is_last;
endmodule

// File: rtl/wsbus_seq_chk.sv
module wsbus_seq_chk #(
   parameter int CNT_W  = 5,
   parameter int BEAT_W = 4
) (
   input logic              clk,
   input logic              sync_rst,
   input logic              test_isolate,
   input logic              req_pending,
   input logic              req_write,
   input logic [BEAT_W-1:0] req_beats,
   input logic [CNT_W-1:0]  rd_a2d_cnt,
   input logic [CNT_W-1:0]  wr_a2d_cnt,
   input logic [CNT_W-1:0]  rd_d2d_cnt,
   input logic [CNT_W-1:0]  wr_d2d_cnt,
   input logic [CNT_W-1:0]  recov_cnt,
   input logic              ext_rdy_en,
   input logic              bus_hold_req,
   input logic              backoff_req,
   input logic              beat_ack,
   input logic              burst_stop,
   input logic [3:0]        state_o,
   input logic              addr_strobe,
   input logic              data_strobe,
   input logic              last_beat
);
   logic in_acc;
   assign in_acc = (state_o == 4'd2) || (state_o == 4'd3) ||
                   (state_o == 4'd5) || (state_o == 4'd6);

   AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (sync_rst)
      state_o <= 4'd8);                                                   // R1
   AST_IDLE_START: assert property (@(posedge clk) disable iff (sync_rst)
      (state_o == 4'd0) && !bus_hold_req && req_pending |=> state_o == 4'd2); // R2
   AST_HOLD_EXIT: assert property (@(posedge clk) disable iff (sync_rst)
      (state_o == 4'd1) && !bus_hold_req |=> state_o == 4'd0);            // R2
   AST_ISO_STAY: assert property (@(posedge clk) disable iff (sync_rst)
      (state_o == 4'd8) && test_isolate |=> state_o == 4'd8);             // R3
   AST_RDY_WAIT: assert property (@(posedge clk) disable iff (sync_rst)
      data_strobe && ext_rdy_en && !beat_ack && !burst_stop && !backoff_req
      |=> data_strobe && $stable(last_beat));                             // R6
   AST_LAST_EXIT: assert property (@(posedge clk) disable iff (sync_rst)
      last_beat && !backoff_req && (!ext_rdy_en || beat_ack || burst_stop)
      |=> !data_strobe);                                                  // R7
   AST_BOFF_ENTER: assert property (@(posedge clk) disable iff (sync_rst)
      in_acc && backoff_req |=> state_o == 4'd4);                         // R9
   AST_BOFF_STAY: assert property (@(posedge clk) disable iff (sync_rst)
      (state_o == 4'd4) && backoff_req |=> state_o == 4'd4);              // R9
endmodule

bind wsbus_seq wsbus_seq_chk #(.CNT_W(CNT_W), .BEAT_W(BEAT_W)) u_chk (.*);

// File: tb/wsbus_seq_bench.sv
`timescale 1ns/1ps
module wsbus_seq_bench;
   localparam int CW = 5;
   localparam int BW = 4;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic sync_rst = 1'b1, test_isolate = 1'b0, req_pending = 1'b0, req_write = 1'b0;
   logic [BW-1:0] req_beats = '0;
   logic [CW-1:0] rd_a2d_cnt = '0, wr_a2d_cnt = '0, rd_d2d_cnt = '0, wr_d2d_cnt = '0, recov_cnt = '0;
   logic ext_rdy_en = 1'b0, bus_hold_req = 1'b0, backoff_req = 1'b0, beat_ack = 1'b0, burst_stop = 1'b0;
   logic [3:0] state_o;
   logic addr_strobe, data_strobe, last_beat;

   wsbus_seq #(.CNT_W(CW), .BEAT_W(BW)) u_wsbus_seq (.*);

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   // Bench model, built from the requirements
   int m_st = 0, m_sav = 0, m_beats = 0;
   int m_a2d = 0, m_d2d = 0, m_rec = 0;
   int m_ca = 0, m_cd = 0, m_cr = 0;

   function automatic int pick_after();
      if (bus_hold_req) return 1;
      if (req_pending)  return 2;
      return 0;
   endfunction

   task automatic model_step();
      int ns, nsav, nb, na2d, nd2d, nrec, nca, ncd, ncr;
      bit beat;
      ns = m_st; nsav = m_sav; nb = m_beats;
      na2d = m_a2d; nd2d = m_d2d; nrec = m_rec;
      nca = m_ca; ncd = m_cd; ncr = m_cr;
      beat = (m_st == 3) && !backoff_req && (!ext_rdy_en || beat_ack || burst_stop);
      if (sync_rst && test_isolate) ns = 8;
      else if (m_st == 8) ns = test_isolate ? 8 : 0;
      else if (sync_rst) ns = 0;
      else case (m_st)
         0: ns = pick_after();
         1: if (!bus_hold_req) ns = 0;
         2: ns = backoff_req ? 4 : (m_a2d != 0 ? 5 : 3);
         5: if (backoff_req) ns = 4; else if (m_ca == 1) ns = 3;
         3: if (backoff_req) ns = 4;
            else if (beat) begin
               if (m_beats <= 1) ns = (m_rec != 0) ? 7 : pick_after();
               else ns = (m_d2d != 0) ? 6 : 3;
            end
         6: if (backoff_req) ns = 4; else if (m_cd == 1) ns = 3;
         7: if (m_cr == 1) ns = pick_after();
         4: if (!backoff_req) ns = m_sav;
         default: ns = 0;
      endcase
      if (sync_rst) begin
         nsav = 0; nb = 0; na2d = 0; nd2d = 0; nrec = 0; nca = 0; ncd = 0; ncr = 0;
      end else begin
         if (ns == 4 && m_st != 4) nsav = m_st;
         if (ns == 2 && (m_st == 0 || m_st == 3 || m_st == 7)) begin
            na2d = req_write ? wr_a2d_cnt : rd_a2d_cnt;
            nd2d = req_write ? wr_d2d_cnt : rd_d2d_cnt;
            nrec = recov_cnt;
            nb   = (req_beats == 0) ? 1 : req_beats;
         end else if (beat && m_beats > 1) nb = m_beats - 1;
         if (ns == 5 && m_st == 2) nca = m_a2d; else if (ns == 5 && m_st == 5) nca = m_ca - 1;
         if (ns == 6 && m_st == 3) ncd = m_d2d; else if (ns == 6 && m_st == 6) ncd = m_cd - 1;
         if (ns == 7 && m_st == 3) ncr = m_rec; else if (ns == 7 && m_st == 7) ncr = m_cr - 1;
      end
      @(posedge clk);
      m_st = ns; m_sav = nsav; m_beats = nb; m_a2d = na2d; m_d2d = nd2d; m_rec = nrec;
      m_ca = nca; m_cd = ncd; m_cr = ncr;
   endtask

   task automatic check(string tag);
      logic [3:0] e_st;
      logic e_a, e_d, e_l;
      e_st = 4'(m_st);
      e_a  = (m_st == 2);
      e_d  = (m_st == 3);
      e_l  = e_d && (m_beats <= 1);
      n_chk++;
      if (state_o !== e_st || addr_strobe !== e_a || data_strobe !== e_d || last_beat !== e_l) begin
         n_bad++;
         $display("FAIL %s: state/as/ds/last got %0d/%b/%b/%b expected %0d/%b/%b/%b",
                  tag, state_o, addr_strobe, data_strobe, last_beat, e_st, e_a, e_d, e_l);
      end
   endtask

   task automatic tick(string tag, int n = 1);
      for (int i = 0; i < n; i++) begin
         model_step();
         @(negedge clk);
         check(tag);
      end
   endtask

   task automatic set_counts(int a, int d, int r);
      rd_a2d_cnt = CW'(a); wr_a2d_cnt = CW'(a);
      rd_d2d_cnt = CW'(d); wr_d2d_cnt = CW'(d);
      recov_cnt  = CW'(r);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240607));
      // R1: reset state
      tick("R1", 3);
      sync_rst = 1'b0;
      tick("R1", 2);

      // R4 R5 R8: read with waits everywhere, write counts differ
      req_write = 1'b0; req_beats = 4'd3; req_pending = 1'b1;
      rd_a2d_cnt = 5'd2; wr_a2d_cnt = 5'd0; rd_d2d_cnt = 5'd1; wr_d2d_cnt = 5'd3; recov_cnt = 5'd2;
      tick("R4", 1);
      req_pending = 1'b0;
      tick("R4", 3);
      tick("R5", 5);
      tick("R8", 4);

      // R10: settings changed mid access are ignored
      req_write = 1'b1; req_beats = 4'd2; set_counts(1, 2, 0); req_pending = 1'b1;
      tick("R10", 1);
      req_pending = 1'b0; req_beats = 4'd7; set_counts(4, 0, 3); req_write = 1'b0;
      tick("R10", 8);

      // R7 R11: zero waits, beat count 0 treated as one, back-to-back accesses
      set_counts(0, 0, 0); req_beats = 4'd0; req_write = 1'b1; req_pending = 1'b1;
      tick("R11", 4);
      req_pending = 1'b0;
      tick("R7", 3);

      // R6: external acknowledge waits, burst stop completes a beat
      ext_rdy_en = 1'b1; req_beats = 4'd2; req_pending = 1'b1;
      tick("R6", 1);
      req_pending = 1'b0;
      tick("R6", 3);
      burst_stop = 1'b1; tick("R6", 1); burst_stop = 1'b0;
      tick("R6", 2);
      beat_ack = 1'b1; tick("R6", 2); beat_ack = 1'b0;
      ext_rdy_en = 1'b0;
      tick("R6", 2);

      // R9: back-off in wait and data states, resume
      req_beats = 4'd2; set_counts(3, 2, 0); req_pending = 1'b1;
      tick("R9", 1);
      req_pending = 1'b0;
      tick("R9", 2);
      backoff_req = 1'b1; tick("R9", 3); backoff_req = 1'b0;
      tick("R9", 3);
      backoff_req = 1'b1; tick("R9", 2); backoff_req = 1'b0;
      tick("R9", 6);

      // R2: hold from idle, hold after last beat with a request pending
      bus_hold_req = 1'b1; tick("R2", 3);
      bus_hold_req = 1'b0; tick("R2", 2);
      set_counts(0, 0, 0); req_beats = 4'd1; req_pending = 1'b1; tick("R2", 2);
      bus_hold_req = 1'b1; tick("R2", 2);
      bus_hold_req = 1'b0; req_pending = 1'b0; tick("R2", 2);

      // R3: isolation with reset, held after reset drops, then released
      sync_rst = 1'b1; test_isolate = 1'b1; tick("R3", 2);
      sync_rst = 1'b0; tick("R3", 3);
      test_isolate = 1'b0; tick("R3", 2);

      // R1: constrained random mix
      for (int c = 0; c < 6000; c++) begin
         req_pending  = ($urandom % 3) != 0;
         req_write    = $urandom % 2;
         req_beats    = BW'($urandom % 5);
         rd_a2d_cnt   = CW'($urandom % 4); wr_a2d_cnt = CW'($urandom % 4);
         rd_d2d_cnt   = CW'($urandom % 4); wr_d2d_cnt = CW'($urandom % 4);
         recov_cnt    = CW'($urandom % 4);
         ext_rdy_en   = ($urandom % 3) == 0;
         beat_ack     = $urandom % 2;
         burst_stop   = ($urandom % 6) == 0;
         bus_hold_req = ($urandom % 15) == 0;
         backoff_req  = ($urandom % 10) == 0;
         sync_rst     = ($urandom % 250) == 0;
         test_isolate = sync_rst ? (($urandom % 2) == 0) : (test_isolate && ($urandom % 3) != 0);
         tick("R1", 1);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule